// File: doc/BRIEF.md
# 36-to-32 Bit Readout Packer

The packer sits between a 36-bit wide sample memory and a 32-bit host link. It takes memory words from a valid/ready stream and gathers them in groups of eight. Once a group is complete, it sends nine 32-bit words on a second valid/ready stream. The first eight carry the low 32 bits of the group's words in arrival order. The ninth carries the eight 4-bit top nibbles. Every outgoing word has its two 16-bit halves exchanged, so that on a byte-serial link the upper half travels first and each half is little-endian.

A transfer is marked by `in_last` on its final memory word. A transfer whose length is a whole number of groups passes through unchanged. If `in_last` arrives inside a group, the unfinished group is discarded, `err_partial` pulses, and the next word starts a new group.

Top module: `pk36_packer`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `err_partial` is 0.
- R2: Each complete group of eight accepted input words yields exactly nine output handshakes. No other output word is ever produced.
- R3: Output words 0 to 7 of a group carry `in_data[31:0]` of input words 0 to 7 of that group, in order, before the half swap of R5.
- R4: Output word 8 of a group is built, before the half swap of R5, with input word k's bits 35:32 in bits 4k+3:4k, for k = 0 to 7.
- R5: For logical word W, `out_data` equals {W[15:0], W[31:16]}. With `out_data[7:0]` taken as the first byte sent, the bytes go out as W[23:16], W[31:24], W[7:0], W[15:8].
- R6: `out_valid` stays 0 until the eighth word of a group has been accepted, and rises in the cycle after that acceptance. While a group is being sent, `in_ready` is 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold in the next cycle. No word is dropped or repeated.
- R8: If `in_last` is accepted with a word other than the eighth of a group, the words of that group are dropped, no output is produced for them, `err_partial` is 1 for exactly the next cycle, and the next accepted word begins a new group.
- R9: If `in_last` is accepted with the eighth word of a group, `err_partial` stays 0 and the group is sent normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Memory word offered |
| in_ready | output | 1 | Packer can take a memory word |
| in_data | input | 36 | Memory word |
| in_last | input | 1 | Final word of a transfer |
| out_valid | output | 1 | Link word offered |
| out_ready | input | 1 | Link can take the word |
| out_data | output | 32 | Link word, halves exchanged |
| err_partial | output | 1 | One-cycle pulse when a transfer ends inside a group |

## Verification
The hardest case to reach from the ports is a stall on the ninth, nibble-carrying word that is immediately followed by a short transfer. That transfer must be dropped without leaving stale nibbles in the store. The bench applies random output stalls for the whole run, so the nibble word is often held for several cycles. Directed transfers ending after one and three words, and one stopped after seven words, are placed right after full groups to show that each new group starts clean.

// File: rtl/pk36_pkg.sv
`timescale 1ns/1ps
package pk36_pkg;
    localparam int GROUP_DEF = 8;
    localparam int LOW_W_DEF = 32;
    localparam int NIB_W_DEF = 4;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } pk_state_e;
endpackage

// File: rtl/pk36_swizzle.sv
`timescale 1ns/1ps
module pk36_swizzle #(
    parameter int W = 32
) (
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);
    localparam int H = W / 2;

    for (genvar b = 0; b < H; b++) begin : g_half
        assign word_o[H + b] = word_i[b];
        assign word_o[b]     = word_i[H + b];
    end
endmodule

// File: rtl/pk36_store.sv
`timescale 1ns/1ps
module pk36_store #(
    parameter int GROUP = 8,
    parameter int LOW_W = 32,
    parameter int NIB_W = 4,
    parameter int IDX_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [LOW_W+NIB_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [LOW_W-1:0]         rd_word
);
    localparam int SEL_W = $clog2(GROUP);
    localparam logic [IDX_W-1:0] NIB_SLOT = IDX_W'(GROUP);

    logic [LOW_W-1:0] low_q [GROUP];
    logic [LOW_W-1:0] low_d [GROUP];
    logic [NIB_W-1:0] nib_q [GROUP];
    logic [NIB_W-1:0] nib_d [GROUP];
    logic [LOW_W-1:0] nib_word;

    always_comb begin
        for (int i = 0; i < GROUP; i++) begin
            low_d[i] = low_q[i];
            nib_d[i] = nib_q[i];
        end
        if (wr_en && (wr_idx < NIB_SLOT)) begin
            low_d[wr_idx[SEL_W-1:0]] = wr_data[LOW_W-1:0];
            nib_d[wr_idx[SEL_W-1:0]] = wr_data[LOW_W+NIB_W-1:LOW_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < GROUP; i++) begin
                low_q[i] <= '0;
                nib_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < GROUP; i++) begin
                low_q[i] <= low_d[i];
                nib_q[i] <= nib_d[i];
            end
        end
    end

    for (genvar g = 0; g < GROUP; g++) begin : g_nib
        assign nib_word[g*NIB_W +: NIB_W] = nib_q[g];
    end

    always_comb begin
        if (rd_idx == NIB_SLOT) rd_word = nib_word;
        else                    rd_word = low_q[rd_idx[SEL_W-1:0]];
    end

    // R4: a write aimed at the nibble slot would corrupt the group
    a_r4_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < NIB_SLOT));
endmodule

// File: rtl/pk36_seq.sv
`timescale 1ns/1ps
module pk36_seq
    import pk36_pkg::*;
#(
    parameter int GROUP = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             wr_en,
    output logic [IDX_W-1:0] idx,
    output logic             err_partial
);
    localparam logic [IDX_W-1:0] LAST_IN  = IDX_W'(GROUP - 1);
    localparam logic [IDX_W-1:0] LAST_OUT = IDX_W'(GROUP);

    typedef struct packed {
        pk_state_e        st;
        logic [IDX_W-1:0] idx;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        accept  = (s_q.st == ST_FILL) && in_valid;
        case (s_q.st)
            ST_FILL: begin
                if (accept) begin
                    if (s_q.idx == LAST_IN) begin
                        s_d.st  = ST_DRAIN;
                        s_d.idx = '0;
                    end else if (in_last) begin
                        s_d.idx = '0;
                        s_d.err = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (out_ready) begin
                    if (s_q.idx == LAST_OUT) begin
                        s_d.st  = ST_FILL;
                        s_d.idx = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_FILL, idx: '0, err: 1'b0};
        else        s_q <= s_d;
    end

    assign in_ready    = (s_q.st == ST_FILL);
    assign out_valid   = (s_q.st == ST_DRAIN);
    assign wr_en       = accept;
    assign idx         = s_q.idx;
    assign err_partial = s_q.err;

    // R2: slot counter never passes the nibble slot
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= LAST_OUT);

    // R6: sending starts only right after an input acceptance
    a_r6_drain_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R8: an error pulse always follows an accepted end marker
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_partial |-> $past(in_valid && in_ready && in_last));

    // R9: ending on the eighth word is not an error
    a_r9_full_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && idx == LAST_IN) |=> !err_partial);
endmodule

// File: rtl/pk36_packer.sv
`timescale 1ns/1ps
module pk36_packer
    import pk36_pkg::*;
#(
    parameter int GROUP = GROUP_DEF,
    parameter int LOW_W = LOW_W_DEF,
    parameter int NIB_W = NIB_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LOW_W+NIB_W-1:0] in_data,
    input  logic                   in_last,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LOW_W-1:0]       out_data,
    output logic                   err_partial
);
    localparam int IDX_W = $clog2(GROUP + 1);

    logic             wr_en;
    logic [IDX_W-1:0] idx;
    logic [LOW_W-1:0] logical_word;

    pk36_seq #(.GROUP(GROUP), .IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .out_ready   (out_ready),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .wr_en       (wr_en),
        .idx         (idx),
        .err_partial (err_partial)
    );

    pk36_store #(.GROUP(GROUP), .LOW_W(LOW_W), .NIB_W(NIB_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (in_data),
        .rd_idx  (idx),
        .rd_word (logical_word)
    );

    pk36_swizzle #(.W(LOW_W)) u_swz (
        .word_i (logical_word),
        .word_o (out_data)
    );

    initial begin
        a_r4_nib_fit: assert (GROUP * NIB_W == LOW_W);
    end

    // R7: a stalled word is held unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: no input is taken while a group is being sent
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

// File: tb/pk36_packer_test.sv
`timescale 1ns/1ps
module pk36_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic        out_ready = 1'b0;
    logic [35:0] in_data = '0;
    logic        in_ready, out_valid, err_partial;
    logic [31:0] out_data;

    int total = 0, bad = 0;
    logic [31:0] exp_q [1024];
    int exp_n = 0, rx_n = 0, grp_n = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic [35:0] ws [8];

    // base (36), step (36), end marker on eighth word, idle gaps
    localparam logic [73:0] VEC [5] = '{
        {36'h0_0000_0000, 36'h1_0000_0001, 1'b1, 1'b0},
        {36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 1'b0, 1'b1},
        {36'h9_1234_5678, 36'h0_0101_0101, 1'b1, 1'b1},
        {36'h5_A5A5_A5A5, 36'h0_0000_0000, 1'b0, 1'b0},
        {36'hA_0F0F_0F0F, 36'h3_3333_3333, 1'b1, 1'b1}
    };

    always #2.5 clk = ~clk;

    pk36_packer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .err_partial(err_partial)
    );

    function automatic logic [31:0] wire_order(logic [31:0] w);
        return {w[15:8], w[7:0], w[31:24], w[23:16]};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic build(logic [35:0] base, logic [35:0] step);
        for (int k = 0; k < 8; k++) ws[k] = base + 36'(k) * step;
    endtask

    task automatic model_group();
        logic [31:0] nib;
        nib = '0;
        for (int k = 0; k < 8; k++) begin
            exp_q[exp_n] = wire_order(ws[k][31:0]);
            exp_n++;
            nib[4*k +: 4] = ws[k][35:32];
        end
        exp_q[exp_n] = wire_order(nib);
        exp_n++;
        grp_n++;
    endtask

    task automatic push(logic [35:0] d, bit last);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_group(logic [35:0] base, logic [35:0] step, bit last, bit gap);
        build(base, step);
        model_group();
        for (int k = 0; k < 8; k++) begin
            if (gap) repeat ($urandom % 3) @(negedge clk);
            push(ws[k], last && (k == 7));
        end
        if (last) begin
            @(negedge clk);
            check(err_partial == 1'b0, "R9 err after full transfer", 32'(err_partial), 32'd0);
        end
    endtask

    // output side: random stalls, compare every handshake, check hold
    initial begin
        bit          held = 1'b0;
        logic [31:0] held_data = '0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (held) begin
                    check(out_valid == 1'b1, "R7 valid held", 32'(out_valid), 32'd1);
                    check(out_data == held_data, "R7 data held", out_data, held_data);
                end
                out_ready = ($urandom % 4) != 0;
                held = out_valid && !out_ready;
                held_data = out_data;
                if (out_valid && out_ready) begin
                    if (rx_n >= exp_n) begin
                        check(1'b0, "R2 unexpected output", out_data, 32'd0);
                    end else if (rx_n % 9 == 8) begin
                        check(out_data == exp_q[rx_n], "R4 R5 nibble word", out_data, exp_q[rx_n]);
                    end else begin
                        check(out_data == exp_q[rx_n], "R3 R5 low word", out_data, exp_q[rx_n]);
                    end
                    rx_n++;
                end
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired rx=%0d expected=%0d", rx_n, exp_n);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
        check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        check(err_partial == 1'b0, "R1 err_partial", 32'(err_partial), 32'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // table of patterns
        for (int i = 0; i < 5; i++)
            send_group(VEC[i][73:38], VEC[i][37:2], VEC[i][1], VEC[i][0]);

        // R6: no output until the eighth word
        build(36'h3_DEAD_BEEF, 36'h8_0000_0011);
        model_group();
        for (int k = 0; k < 7; k++) push(ws[k], 1'b0);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R6 valid before eighth", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R6 ready before eighth", 32'(in_ready), 32'd1);
        push(ws[7], 1'b0);
        @(negedge clk);
        check(out_valid == 1'b1, "R6 valid after eighth", 32'(out_valid), 32'd1);
        check(in_ready == 1'b0, "R6 ready while sending", 32'(in_ready), 32'd0);

        // R8: transfer ends after three words
        push(36'hF_1111_1111, 1'b0);
        push(36'hF_2222_2222, 1'b0);
        push(36'hF_3333_3333, 1'b1);
        @(negedge clk);
        check(err_partial == 1'b1, "R8 pulse", 32'(err_partial), 32'd1);
        @(negedge clk);
        check(err_partial == 1'b0, "R8 pulse width", 32'(err_partial), 32'd0);
        check(out_valid == 1'b0, "R8 no output", 32'(out_valid), 32'd0);
        send_group(36'h6_0000_0100, 36'h1_0000_0007, 1'b1, 1'b0);

        // R8: transfer of a single word
        push(36'hE_ABCD_EF01, 1'b1);
        @(negedge clk);
        check(err_partial == 1'b1, "R8 single word pulse", 32'(err_partial), 32'd1);
        send_group(36'hC_8000_0001, 36'h7_0F00_00F0, 1'b0, 1'b1);

        // R2: all words delivered
        for (int t = 0; t < 2000 && rx_n < exp_n; t++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(rx_n == exp_n, "R2 output count", 32'(rx_n), 32'(exp_n));
        check(rx_n == 9 * grp_n, "R2 nine per group", 32'(rx_n), 32'(9 * grp_n));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule